// File: doc/BRIEF.md
# Interrupt Source PQ Coalescing Controller

This block keeps a bank of interrupt sources, each with a two-bit coalescing state. P marks a source whose event has already been handed to the downstream queue and is waiting for end-of-interrupt. Q marks a source that fired again while P was set. A source therefore sits in the queue at most once. Triggers that arrive while it waits are folded into Q, and the end-of-interrupt replays them as a single new event.

Software reaches each source through a memory-mapped page. The offset inside that page selects the operation. A load can end the interrupt, read the state, or force the state to any of the four values. Each of these loads returns the prior state and updates the state in the same cycle. A store can end the interrupt on sources that are allowed to accept it. A store into a second page raises a trigger without the hardware line. When an event has to be queued, the block raises a valid/ready notification that carries the source number.

The address is split as follows, from the top bit down:
- the source index, in the high bits;
- one bit that selects the trigger page (1) or the control page (0);
- the in-page offset, in the low PAGE_BITS bits.

Top module: `pq_coalesce_ctrl`

## Requirements
- R1: After reset every source reads PQ=00, ntf_valid is 0 and rsp_valid is 0.
- R2: A trigger (hw_trig bit) moves PQ 00 to 10 and queues one notification for that source. It moves 10 to 11, 11 to 11 and 01 to 11 without any notification.
- R3: A load at offset 0x000 ends the interrupt and returns the prior PQ in rsp_data[1:0], with P as bit 1 (0x2) and Q as bit 0 (0x1). If Q was set, the state becomes 10 and one notification is queued. If Q was clear, the state becomes 00 and no notification is queued.
- R4: A load at offset 0x800 returns the current PQ and leaves it unchanged.
- R5: Loads at offsets 0xC00, 0xD00, 0xE00 and 0xF00 set PQ to 00, 01, 10 and 11 in that order. Each returns the prior PQ and queues no notification.
- R6: A store at offset 0x400 ends the interrupt as in R3 but gives no response. It takes effect only when store_eoi_cap for that source is 1; otherwise the state is unchanged and nothing is queued.
- R7: A store with the trigger-page address bit set acts as a trigger for the addressed source, exactly as in R2.
- R8: When a trigger and a state-changing load hit the same source in the same cycle, the load returns the state from before both. The trigger is applied after the load's update.
- R9: While ntf_ready is low, ntf_valid stays high with ntf_src unchanged. The events held back are then issued lowest source number first, each exactly once.
- R10: Every load gets exactly one response: rsp_valid is high in the cycle after the request cycle, and upper data bits are zero. Stores never raise rsp_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hw_trig | input | N_SRC | Per-source trigger pulse, one cycle per trigger |
| store_eoi_cap | input | N_SRC | Per-source permission for store end-of-interrupt |
| mmio_valid | input | 1 | Access request present this cycle |
| mmio_write | input | 1 | 1 for store, 0 for load |
| mmio_addr | input | ADDR_W | Source index, trigger-page bit, in-page offset |
| rsp_valid | output | 1 | Load data valid |
| rsp_data | output | DATA_W | Prior PQ in bits [1:0], zero above |
| ntf_valid | output | 1 | Notification offered |
| ntf_ready | input | 1 | Downstream accepts notification |
| ntf_src | output | SRC_W | Source number of the offered notification |

## Verification
The bench targets the following cases and the failure each one exposes:
- **01 masked state:** a trigger must reach 11 silently. A design that treats 01 like 00 would emit a spurious notification.
- **End-of-interrupt with Q set:** it must replay exactly one event. A design that only clears P would lose the coalesced trigger.
- **Trigger and end-of-interrupt in the same cycle on one source:** the bench checks both the returned value and the single resulting event. A non-atomic update would return the post-update state or drop the trigger.
- **Events held behind a low ready:** the bench checks that the offered source holds steady and that the backlog drains lowest-number-first. A design that re-arbitrates under stall would change ntf_src mid-offer.

// File: rtl/pq_pkg.sv
package pq_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_EOI  = 2'd1,
    OP_GET  = 2'd2,
    OP_SET  = 2'd3
  } pq_op_e;

  // in-page offset bits [top:top-1] select the operation
  localparam logic [1:0] SEL_EOI_LD = 2'b00;
  localparam logic [1:0] SEL_EOI_ST = 2'b01;
  localparam logic [1:0] SEL_GET    = 2'b10;
  localparam logic [1:0] SEL_SET    = 2'b11;

  localparam logic [1:0] PQ_IDLE = 2'b00;
  localparam logic [1:0] PQ_P    = 2'b10;
  localparam logic [1:0] PQ_PQ   = 2'b11;
endpackage

// File: rtl/pq_req_decode.sv
module pq_req_decode
  import pq_pkg::*;
#(
  parameter int N_SRC     = 8,
  parameter int SRC_W     = 3,
  parameter int PAGE_BITS = 12,
  parameter int ADDR_W    = SRC_W + 1 + PAGE_BITS
) (
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_SRC-1:0]  cap_i,
  output logic [N_SRC-1:0]  op_hit_o,
  output logic [N_SRC-1:0]  page_trig_o,
  output pq_op_e            op_o,
  output logic [1:0]        setv_o,
  output logic              rsp_en_o,
  output logic              rsp_state_o,
  output logic [SRC_W-1:0]  src_o
);
  logic [SRC_W-1:0] src;
  logic             pg_trig;
  logic [1:0]       sel;
  logic             in_rng;
  logic             trig_hit;
  pq_op_e           op;

  always_comb begin
    src     = addr_i[ADDR_W-1 -: SRC_W];
    pg_trig = addr_i[PAGE_BITS];
    sel     = addr_i[PAGE_BITS-1 -: 2];
    setv_o  = addr_i[PAGE_BITS-3 -: 2];
    in_rng  = (int'(src) < N_SRC);
    op      = OP_NONE;
    if (valid_i && in_rng && !pg_trig) begin
      if (!write_i) begin
        case (sel)
          SEL_EOI_LD: op = OP_EOI;
          SEL_GET:    op = OP_GET;
          SEL_SET:    op = OP_SET;
          default:    op = OP_NONE;
        endcase
      end else if (sel == SEL_EOI_ST && cap_i[src]) begin
        op = OP_EOI;
      end
    end
    trig_hit = valid_i && write_i && pg_trig && in_rng;
    for (int i = 0; i < N_SRC; i++) begin
      op_hit_o[i]    = (src == SRC_W'(i)) && (op != OP_NONE);
      page_trig_o[i] = (src == SRC_W'(i)) && trig_hit;
    end
    op_o        = op;
    rsp_en_o    = valid_i && !write_i;
    rsp_state_o = (op != OP_NONE) && !write_i;
    src_o       = src;
  end

  logic unused_low_bits;
  assign unused_low_bits = ^addr_i[PAGE_BITS-5:0];
endmodule

// File: rtl/pq_src_cell.sv
module pq_src_cell
  import pq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_hit_i,
  input  pq_op_e     op_i,
  input  logic [1:0] setv_i,
  input  logic       trig_i,
  output logic [1:0] pq_o,
  output logic       event_o
);
  logic [1:0] pq_q, pq_mid, pq_d;
  logic       ev_eoi, ev_trig, pq_en;

  always_comb begin
    pq_mid = pq_q;
    ev_eoi = 1'b0;
    if (op_hit_i) begin
      case (op_i)
        OP_EOI: begin
          if (pq_q[0]) begin
            pq_mid = PQ_P;
            ev_eoi = 1'b1;
          end else begin
            pq_mid = PQ_IDLE;
          end
        end
        OP_SET:  pq_mid = setv_i;
        default: pq_mid = pq_q;
      endcase
    end
    pq_d    = pq_mid;
    ev_trig = 1'b0;
    if (trig_i) begin
      if (pq_mid == PQ_IDLE) begin
        pq_d    = PQ_P;
        ev_trig = 1'b1;
      end else begin
        pq_d = PQ_PQ;
      end
    end
    pq_en   = op_hit_i || trig_i;
    event_o = ev_eoi || ev_trig;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pq_q <= PQ_IDLE;
    else if (pq_en)  pq_q <= pq_d;
  end

  assign pq_o = pq_q;

  assert_trig_sets_p_R2: assert property (@(posedge clk) disable iff (!rst_n)
    trig_i |=> pq_q[1]);
  assert_event_marks_p_R3: assert property (@(posedge clk) disable iff (!rst_n)
    event_o |=> pq_q[1]);
  assert_get_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_hit_i && op_i == OP_GET && !trig_i) |=> $stable(pq_q));
  assert_force_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_hit_i && op_i == OP_SET && !trig_i) |=> (pq_q == $past(setv_i)));
endmodule

// File: rtl/pq_ntf_arb.sv
module pq_ntf_arb #(
  parameter int N_SRC = 8,
  parameter int SRC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] event_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [SRC_W-1:0] src_o
);
  logic [N_SRC-1:0] pend_q, pend_d, take;
  logic             out_valid_q, out_valid_d;
  logic [SRC_W-1:0] out_src_q, out_src_d, pick;
  logic             any, load;

  always_comb begin
    pick = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pend_q[i]) pick = SRC_W'(i);
    end
    any  = |pend_q;
    load = !out_valid_q || ready_i;
    take = '0;
    if (load && any) take[pick] = 1'b1;
    pend_d      = (pend_q & ~take) | event_i;
    out_valid_d = load ? any : out_valid_q;
    out_src_d   = (load && any) ? pick : out_src_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= '0;
      out_valid_q <= 1'b0;
      out_src_q   <= '0;
    end else begin
      pend_q      <= pend_d;
      out_valid_q <= out_valid_d;
      if (load) out_src_q <= out_src_d;
    end
  end

  assign valid_o = out_valid_q;
  assign src_o   = out_src_q;

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_q && !ready_i) |=> (out_valid_q && $stable(out_src_q)));
  assert_event_issued_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|event_i) |=> (out_valid_q || (|pend_q)));
endmodule

// File: rtl/pq_coalesce_ctrl.sv
module pq_coalesce_ctrl
  import pq_pkg::*;
#(
  parameter int N_SRC     = 8,
  parameter int PAGE_BITS = 12,
  parameter int DATA_W    = 64,
  localparam int SRC_W    = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int ADDR_W   = SRC_W + 1 + PAGE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  hw_trig,
  input  logic [N_SRC-1:0]  store_eoi_cap,
  input  logic              mmio_valid,
  input  logic              mmio_write,
  input  logic [ADDR_W-1:0] mmio_addr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              ntf_valid,
  input  logic              ntf_ready,
  output logic [SRC_W-1:0]  ntf_src
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [N_SRC-1:0]      op_hit, page_trig, src_event;
  logic [N_SRC-1:0][1:0] pq_all;
  pq_op_e                op;
  logic [1:0]            setv;
  logic                  rsp_en, rsp_state;
  logic [SRC_W-1:0]      req_src;

  pq_req_decode #(
    .N_SRC(N_SRC), .SRC_W(SRC_W), .PAGE_BITS(PAGE_BITS), .ADDR_W(ADDR_W)
  ) u_decode (
    .valid_i(mmio_valid), .write_i(mmio_write), .addr_i(mmio_addr),
    .cap_i(store_eoi_cap), .op_hit_o(op_hit), .page_trig_o(page_trig),
    .op_o(op), .setv_o(setv), .rsp_en_o(rsp_en), .rsp_state_o(rsp_state),
    .src_o(req_src)
  );

  for (genvar g = 0; g < N_SRC; g++) begin : g_cell
    pq_src_cell u_cell (
      .clk(clk), .rst_n(rst_int_n), .op_hit_i(op_hit[g]), .op_i(op),
      .setv_i(setv), .trig_i(hw_trig[g] | page_trig[g]),
      .pq_o(pq_all[g]), .event_o(src_event[g])
    );
  end

  pq_ntf_arb #(.N_SRC(N_SRC), .SRC_W(SRC_W)) u_arb (
    .clk(clk), .rst_n(rst_int_n), .event_i(src_event),
    .ready_i(ntf_ready), .valid_o(ntf_valid), .src_o(ntf_src)
  );

  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_data_q, rsp_data_d;

  always_comb begin
    rsp_data_d = '0;
    if (rsp_state) rsp_data_d[1:0] = pq_all[req_src];
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= rsp_en;
      if (rsp_en) rsp_data_q <= rsp_data_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;

  assert_store_no_rsp_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mmio_valid && mmio_write) |=> !rsp_valid);
  assert_load_rsp_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mmio_valid && !mmio_write) |=> (rsp_valid && rsp_data[DATA_W-1:2] == '0));
  assert_idle_no_rsp_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    !mmio_valid |=> !rsp_valid);
endmodule

// File: tb/tb_pq_coalesce_ctrl.sv
`timescale 1ns/1ps
module tb_pq_coalesce_ctrl;
  localparam int N      = 8;
  localparam int SW     = 3;
  localparam int PB     = 12;
  localparam int AW     = SW + 1 + PB;
  localparam int DW     = 64;

  logic          clk, rst_n;
  logic [N-1:0]  hw_trig, store_eoi_cap;
  logic          mmio_valid, mmio_write;
  logic [AW-1:0] mmio_addr;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic          ntf_valid, ntf_ready;
  logic [SW-1:0] ntf_src;

  pq_coalesce_ctrl #(.N_SRC(N), .PAGE_BITS(PB), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .hw_trig(hw_trig), .store_eoi_cap(store_eoi_cap),
    .mmio_valid(mmio_valid), .mmio_write(mmio_write), .mmio_addr(mmio_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .ntf_valid(ntf_valid),
    .ntf_ready(ntf_ready), .ntf_src(ntf_src)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  int ntf_cnt  = 0;
  int log_src [0:255];

  // handshake monitor, samples 1 ns before the rising edge
  always begin
    @(negedge clk);
    #9;
    if (ntf_valid && ntf_ready) begin
      log_src[ntf_cnt % 256] = int'(ntf_src);
      ntf_cnt = ntf_cnt + 1;
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mk(input int s, input bit tp, input logic [11:0] off);
    return {SW'(s), tp, off};
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_load(input int s, input logic [11:0] off, output logic [63:0] d, output logic v);
    @(negedge clk);
    mmio_valid = 1'b1; mmio_write = 1'b0; mmio_addr = mk(s, 1'b0, off);
    @(negedge clk);
    mmio_valid = 1'b0;
    v = rsp_valid;
    d = rsp_data;
  endtask

  task automatic do_store(input int s, input bit tp, input logic [11:0] off, output logic v);
    @(negedge clk);
    mmio_valid = 1'b1; mmio_write = 1'b1; mmio_addr = mk(s, tp, off);
    @(negedge clk);
    mmio_valid = 1'b0; mmio_write = 1'b0;
    v = rsp_valid;
  endtask

  task automatic pulse(input int s);
    @(negedge clk);
    hw_trig[s] = 1'b1;
    @(negedge clk);
    hw_trig = '0;
  endtask

  task automatic get_state(input int s, output logic [63:0] d);
    logic v;
    do_load(s, 12'h800, d, v);
  endtask

  task automatic t_reset;
    logic [63:0] d; logic v;
    check("R1 ntf_valid after reset", {63'b0, ntf_valid}, 64'd0);
    check("R1 rsp_valid after reset", {63'b0, rsp_valid}, 64'd0);
    do_load(0, 12'h800, d, v);
    check("R1 src0 state", d, 64'd0);
    do_load(7, 12'h800, d, v);
    check("R1 src7 state", d, 64'd0);
    check("R10 load response valid", {63'b0, v}, 64'd1);
  endtask

  task automatic t_trigger;
    logic [63:0] d; logic v; int c0;
    c0 = ntf_cnt;
    pulse(2); idle(5);
    check("R2 00->10 notifies", 64'(ntf_cnt - c0), 64'd1);
    check("R2 notified source", 64'(log_src[c0 % 256]), 64'd2);
    get_state(2, d);
    check("R2 state 10", d, 64'd2);
    pulse(2); idle(5);
    get_state(2, d);
    check("R2 state 11", d, 64'd3);
    pulse(2); idle(5);
    get_state(2, d);
    check("R2 11 stays 11", d, 64'd3);
    check("R2 no extra notify", 64'(ntf_cnt - c0), 64'd1);
    do_load(3, 12'hD00, d, v);
    check("R5 force 01 returns 00", d, 64'd0);
    pulse(3); idle(5);
    get_state(3, d);
    check("R2 01 -> 11", d, 64'd3);
    check("R2 01 masked no notify", 64'(ntf_cnt - c0), 64'd1);
  endtask

  task automatic t_eoi_load;
    logic [63:0] d; logic v; int c0;
    c0 = ntf_cnt;
    do_load(2, 12'h000, d, v);
    check("R3 eoi returns 11", d, 64'd3);
    check("R10 eoi response valid", {63'b0, v}, 64'd1);
    idle(5);
    check("R3 replay notify", 64'(ntf_cnt - c0), 64'd1);
    check("R3 replay source", 64'(log_src[c0 % 256]), 64'd2);
    get_state(2, d);
    check("R3 state after replay", d, 64'd2);
    get_state(2, d);
    check("R4 get leaves state", d, 64'd2);
    do_load(2, 12'h000, d, v);
    check("R3 eoi returns 10", d, 64'd2);
    idle(5);
    get_state(2, d);
    check("R3 state 00", d, 64'd0);
    check("R3 no notify when Q clear", 64'(ntf_cnt - c0), 64'd1);
  endtask

  task automatic t_force;
    logic [63:0] d; logic v; int c0;
    c0 = ntf_cnt;
    do_load(4, 12'hF00, d, v);
    check("R5 F00 returns 00", d, 64'd0);
    do_load(4, 12'hE00, d, v);
    check("R5 E00 returns 11", d, 64'd3);
    do_load(4, 12'hD00, d, v);
    check("R5 D00 returns 10", d, 64'd2);
    do_load(4, 12'hC00, d, v);
    check("R5 C00 returns 01", d, 64'd1);
    get_state(4, d);
    check("R5 final 00", d, 64'd0);
    idle(4);
    check("R5 no notify on force", 64'(ntf_cnt - c0), 64'd0);
  endtask

  task automatic t_store_eoi;
    logic [63:0] d; logic v; int c0;
    pulse(5); pulse(5); idle(5);
    c0 = ntf_cnt;
    do_store(5, 1'b0, 12'h400, v);
    check("R10 store no response", {63'b0, v}, 64'd0);
    idle(5);
    get_state(5, d);
    check("R6 store eoi replays to 10", d, 64'd2);
    check("R6 store eoi notify", 64'(ntf_cnt - c0), 64'd1);
    do_load(6, 12'hF00, d, v);
    c0 = ntf_cnt;
    do_store(6, 1'b0, 12'h400, v);
    idle(5);
    get_state(6, d);
    check("R6 store ignored without cap", d, 64'd3);
    check("R6 no notify without cap", 64'(ntf_cnt - c0), 64'd0);
  endtask

  task automatic t_trig_page;
    logic [63:0] d; logic v; int c0;
    c0 = ntf_cnt;
    do_store(1, 1'b1, 12'h000, v);
    idle(5);
    get_state(1, d);
    check("R7 trigger page sets P", d, 64'd2);
    check("R7 trigger page notify", 64'(ntf_cnt - c0), 64'd1);
    check("R7 notified source", 64'(log_src[c0 % 256]), 64'd1);
  endtask

  task automatic t_atomic;
    logic [63:0] d; logic v; int c0;
    do_load(0, 12'hF00, d, v);
    idle(4);
    c0 = ntf_cnt;
    @(negedge clk);
    mmio_valid = 1'b1; mmio_write = 1'b0; mmio_addr = mk(0, 1'b0, 12'h000);
    hw_trig[0] = 1'b1;
    @(negedge clk);
    mmio_valid = 1'b0; hw_trig = '0;
    check("R8 eoi+trig returns prior 11", rsp_data, 64'd3);
    idle(5);
    get_state(0, d);
    check("R8 state 11 after eoi+trig", d, 64'd3);
    check("R8 one notify", 64'(ntf_cnt - c0), 64'd1);
    do_load(0, 12'hE00, d, v);
    idle(4);
    c0 = ntf_cnt;
    @(negedge clk);
    mmio_valid = 1'b1; mmio_write = 1'b0; mmio_addr = mk(0, 1'b0, 12'h000);
    hw_trig[0] = 1'b1;
    @(negedge clk);
    mmio_valid = 1'b0; hw_trig = '0;
    check("R8 eoi+trig returns prior 10", rsp_data, 64'd2);
    idle(5);
    get_state(0, d);
    check("R8 trigger after eoi gives 10", d, 64'd2);
    check("R8 trigger after eoi notifies", 64'(ntf_cnt - c0), 64'd1);
  endtask

  task automatic t_order;
    logic [63:0] d; logic v; int c0;
    do_load(6, 12'hC00, d, v);
    do_load(1, 12'hC00, d, v);
    do_load(4, 12'hC00, d, v);
    idle(4);
    c0 = ntf_cnt;
    @(negedge clk); ntf_ready = 1'b0;
    pulse(6); pulse(1); pulse(4);
    idle(3);
    check("R9 valid while stalled", {63'b0, ntf_valid}, 64'd1);
    check("R9 first offered source", 64'(ntf_src), 64'd6);
    idle(4);
    check("R9 source held under stall", 64'(ntf_src), 64'd6);
    check("R9 nothing taken under stall", 64'(ntf_cnt - c0), 64'd0);
    @(negedge clk); ntf_ready = 1'b1;
    idle(8);
    check("R9 all drained", 64'(ntf_cnt - c0), 64'd3);
    check("R9 order 1st", 64'(log_src[c0 % 256]), 64'd6);
    check("R9 order 2nd", 64'(log_src[(c0 + 1) % 256]), 64'd1);
    check("R9 order 3rd", 64'(log_src[(c0 + 2) % 256]), 64'd4);
    check("R9 valid low after drain", {63'b0, ntf_valid}, 64'd0);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; hw_trig = '0; store_eoi_cap = 8'b0010_0000;
    mmio_valid = 1'b0; mmio_write = 1'b0; mmio_addr = '0; ntf_ready = 1'b1;
    idle(3);
    @(negedge clk); rst_n = 1'b1;
    idle(4);
    t_reset();
    t_trigger();
    t_eoi_load();
    t_force();
    t_store_eoi();
    t_trig_page();
    t_atomic();
    t_order();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule